// File: doc/BRIEF.md
# Link Low-Power Entry Idle Timer

This block sits in a serial-link endpoint controller and decides when the link should be asked to go into one of two low-power states. The first is a shallow standby state, entered after the link has stayed idle for a short time. The second is a deeper sleep state, entered only once every function in the endpoint has left its fully-on device power state. Each decision comes from a separate idle counter. Each counter is compared against a threshold given in core clock cycles.

Both thresholds are held in one 32-bit software register. Each is a 12-bit field, and software sets it to the wanted time in microseconds multiplied by the core clock in MHz. When a counter reaches its threshold, the block sends a one-cycle request to the link power logic. That logic carries out the actual state change and its handshakes.

Top module: `link_pm_timer`

## Requirements
- R1: After reset `regRdData` reads 0x0014D7CE. The deep-state threshold in bits 23:12 is 0x14D, the shallow-state threshold in bits 11:0 is 0x7CE, and bits 31:24 are zero.
- R2: A cycle with `regWrEn` high loads bits 23:0 of `regWrData` into the register, visible on `regRdData` in the next cycle. Bits 31:24 ignore writes and always read zero.
- R3: The shallow counter advances by one on every clock edge at which `linkIdle` is 1 and `trafficPending` is 0. It wraps modulo 4096. On the edge where it reaches the nonzero threshold in bits 11:0, `l0sReq` is 1 for the following cycle.
- R4: An edge with `linkIdle` at 0 or `trafficPending` at 1 clears the shallow counter to zero. A full threshold of qualified edges is needed again before `l0sReq`.
- R5: The deep counter advances only on edges where every bit of `funcNonD0` is 1. On the edge where it reaches the nonzero threshold in bits 23:12, `l1Req` is 1 for the following cycle.
- R6: An edge where any bit of `funcNonD0` is 0 clears the deep counter to zero.
- R7: Each request is a single-cycle pulse. It does not rise again until its counter has been cleared by a loss of qualification.
- R8: A threshold field of zero means its request never rises.
- R9: The two counters run independently. Each request's timing depends only on its own qualification and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register contents |
| linkIdle | input | 1 | Link has no activity |
| trafficPending | input | 1 | Transmit traffic is waiting |
| funcNonD0 | input | NUM_FUNC | Per function: 1 when outside the fully-on device power state |
| l0sReq | output | 1 | One-cycle request to enter the shallow low-power state |
| l1Req | output | 1 | One-cycle request to enter the deep low-power state |

## Verification
The bench builds the block with NUM_FUNC set to 3. This makes the deep counter depend on an all-ones check over a vector wider than one bit, with a single function dropping back to the fully-on state in the middle of a count. The bench writes thresholds between 0 and about 24, so thousands of pulses, clears, zero-threshold runs and threshold changes in the middle of a count fit in a short run. One directed pass keeps the reset value of 0x14D and waits for the deep request after exactly 333 qualified edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int FIELD_W  = 12;
  localparam int NUM_CH   = 2;
  localparam int CH_L0S   = 0;
  localparam int CH_L1    = 1;
  localparam int CFG_W    = NUM_CH * FIELD_W;  // bits 23:0 writable
  localparam int REG_W    = 32;

  typedef struct packed {
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] inc;
  } strobe_t;
endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter logic [FIELD_W-1:0] L0S_DEFAULT = 12'h7CE,
  parameter logic [FIELD_W-1:0] L1_DEFAULT  = 12'h14D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  strobe_t           strb,
  output logic [REG_W-1:0]  regRdData,
  output logic [NUM_CH-1:0] nearThr
);
  localparam logic [CFG_W-1:0] CFG_RESET = {L1_DEFAULT, L0S_DEFAULT};

  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgQ <= CFG_RESET;
    else if (regWrEn) cfgQ <= regWrData[CFG_W-1:0];
  end

  assign regRdData = {{(REG_W-CFG_W){1'b0}}, cfgQ};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [FIELD_W-1:0] thr;
    logic [FIELD_W-1:0] cntQ;
    logic [FIELD_W:0]   cntPlus;

    assign thr     = cfgQ[ch*FIELD_W +: FIELD_W];
    assign cntPlus = {1'b0, cntQ} + 1'b1;
    assign nearThr[ch] = (thr != '0) && (cntPlus == {1'b0, thr});

    always_ff @(posedge clk) begin
      if (!rstN || strb.clr[ch]) cntQ <= '0;
      else if (strb.inc[ch])     cntQ <= cntPlus[FIELD_W-1:0];
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] runVec,
  input  logic [NUM_CH-1:0] nearThr,
  output strobe_t           strb,
  output logic [NUM_CH-1:0] reqVec
);
  logic [NUM_CH-1:0] doneQ;
  logic [NUM_CH-1:0] fire;

  always_comb begin
    strb.clr = ~runVec;
    strb.inc = runVec & ~doneQ;
    fire     = strb.inc & nearThr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ  <= '0;
      reqVec <= '0;
    end else begin
      doneQ  <= (doneQ | fire) & runVec;
      reqVec <= fire;
    end
  end
endmodule

// File: rtl/link_pm_timer.sv
module link_pm_timer
  import lpm_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter logic [FIELD_W-1:0] L0S_DEFAULT = 12'h7CE,
  parameter logic [FIELD_W-1:0] L1_DEFAULT  = 12'h14D
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                linkIdle,
  input  logic                trafficPending,
  input  logic [NUM_FUNC-1:0] funcNonD0,
  output logic                l0sReq,
  output logic                l1Req
);
  strobe_t           strb;
  logic [NUM_CH-1:0] nearThr;
  logic [NUM_CH-1:0] runVec;
  logic [NUM_CH-1:0] reqVec;

  assign runVec[CH_L0S] = linkIdle & ~trafficPending;
  assign runVec[CH_L1]  = &funcNonD0;

  lpm_datapath #(.L0S_DEFAULT(L0S_DEFAULT), .L1_DEFAULT(L1_DEFAULT)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .strb(strb), .regRdData(regRdData), .nearThr(nearThr)
  );

  lpm_ctrl ctl_i (
    .clk(clk), .rstN(rstN), .runVec(runVec), .nearThr(nearThr),
    .strb(strb), .reqVec(reqVec)
  );

  assign l0sReq = reqVec[CH_L0S];
  assign l1Req  = reqVec[CH_L1];
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(parameter int NUM_FUNC = 4) (
  input logic                clk,
  input logic                rstN,
  input logic                linkIdle,
  input logic                trafficPending,
  input logic [NUM_FUNC-1:0] funcNonD0,
  input logic [31:0]         regRdData,
  input logic                l0sReq,
  input logic                l1Req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[31:24] == 8'h00); // R2
  AST_L0S_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    l0sReq |-> $past(linkIdle && !trafficPending)); // R4
  AST_L1_NEEDS_NOND0: assert property (@(posedge clk) disable iff (!rstN)
    l1Req |-> $past(&funcNonD0)); // R6
  AST_L0S_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    l0sReq |=> !l0sReq); // R7
  AST_L1_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    l1Req |=> !l1Req); // R7
  AST_L0S_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(regRdData[11:0] == 12'h000) |-> !l0sReq); // R8
  AST_L1_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $past(regRdData[23:12] == 12'h000) |-> !l1Req); // R8
endmodule

bind link_pm_timer lpm_checker #(.NUM_FUNC(NUM_FUNC)) chk_i (
  .clk(clk), .rstN(rstN), .linkIdle(linkIdle), .trafficPending(trafficPending),
  .funcNonD0(funcNonD0), .regRdData(regRdData), .l0sReq(l0sReq), .l1Req(l1Req)
);

// File: tb/link_pm_timer_tb.sv
module link_pm_timer_tb_top;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [31:0]   regWrData;
  logic [31:0]   regRdData;
  logic          linkIdle;
  logic          trafficPending;
  logic [NF-1:0] funcNonD0;
  logic          l0sReq;
  logic          l1Req;

  always #5ns clk = ~clk;

  link_pm_timer #(.NUM_FUNC(NF)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .linkIdle(linkIdle), .trafficPending(trafficPending),
    .funcNonD0(funcNonD0), .l0sReq(l0sReq), .l1Req(l1Req)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int pulses0 = 0;
  int pulses1 = 0;
  string tag0 = "R3";
  string tag1 = "R5";

  // reference state
  logic [11:0] mThr [2];
  logic [11:0] mCnt [2];
  logic        mDone [2];
  logic        expReq [2];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic stepChan(int ch, logic run);
    logic f = 1'b0;
    if (!run) begin
      mCnt[ch] = '0; mDone[ch] = 1'b0;
    end else if (!mDone[ch]) begin
      mCnt[ch] = mCnt[ch] + 1'b1;
      if (mThr[ch] != 0 && mCnt[ch] == mThr[ch]) begin
        mDone[ch] = 1'b1; f = 1'b1;
      end
    end
    return f;
  endfunction

  function automatic logic [31:0] expReg();
    return {8'h00, mThr[1], mThr[0]};
  endfunction

  // inputs are set before the call, at a falling edge
  task automatic cycle();
    expReq[0] = stepChan(0, linkIdle && !trafficPending);
    expReq[1] = stepChan(1, &funcNonD0);
    if (regWrEn) begin
      mThr[0] = regWrData[11:0];
      mThr[1] = regWrData[23:12];
    end
    @(posedge clk);
    @(negedge clk);
    check(tag0, {31'd0, l0sReq}, {31'd0, expReq[0]});
    check(tag1, {31'd0, l1Req}, {31'd0, expReq[1]});
    check("R2", regRdData, expReg());
    if (l0sReq) pulses0++;
    if (l1Req) pulses1++;
  endtask

  task automatic writeReg(logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    cycle();
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0;
    linkIdle = 1'b0; trafficPending = 1'b0; funcNonD0 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mThr[0] = 12'h7CE; mThr[1] = 12'h14D;
    for (int c = 0; c < 2; c++) begin mCnt[c] = '0; mDone[c] = 1'b0; end
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  function automatic logic [11:0] rndThr();
    if ($urandom_range(7) == 0) return 12'h000;
    return 12'($urandom_range(24, 1));
  endfunction

  initial begin
    void'($urandom(32'd20240517));
    doReset();
    check("R1", regRdData, 32'h0014D7CE);
    check("R1", {30'd0, l0sReq, l1Req}, 32'd0);

    // R1: default deep threshold, pulse after 333 qualified edges
    tag1 = "R1"; funcNonD0 = '1;
    runFor(332);
    check("R1", {31'd0, l1Req}, 32'd0);
    cycle();
    check("R1", {31'd0, l1Req}, 32'd1);
    funcNonD0 = '0; cycle(); tag1 = "R5";

    // R2: reserved bits ignore writes
    writeReg(32'hFF00_7005);
    check("R2", regRdData, 32'h0000_7005);

    // R3 then R7: shallow pulse once per idle period
    tag0 = "R3"; linkIdle = 1'b1; trafficPending = 1'b0;
    pulses0 = 0; runFor(6);
    check("R3", pulses0, 1);
    tag0 = "R7"; runFor(12);
    check("R7", pulses0, 1);

    // R4: traffic and idle loss restart the count
    tag0 = "R4"; linkIdle = 1'b0; cycle();
    linkIdle = 1'b1; runFor(4);
    trafficPending = 1'b1; cycle();
    trafficPending = 1'b0; pulses0 = 0; runFor(4);
    check("R4", pulses0, 0);
    cycle();
    check("R4", pulses0, 1);

    // R5/R6: deep counter over all functions
    linkIdle = 1'b0; writeReg(32'h0000_8005);
    tag1 = "R6"; funcNonD0 = 3'b011; runFor(10);
    funcNonD0 = 3'b111; runFor(5);
    funcNonD0 = 3'b101; cycle();
    funcNonD0 = 3'b111; pulses1 = 0; runFor(7);
    check("R6", pulses1, 0);
    tag1 = "R5"; cycle();
    check("R5", pulses1, 1);

    // R8: zero thresholds
    funcNonD0 = '0; linkIdle = 1'b0; writeReg(32'h0000_0000);
    tag0 = "R8"; tag1 = "R8"; linkIdle = 1'b1; funcNonD0 = '1;
    pulses0 = 0; pulses1 = 0; runFor(4200);
    check("R8", pulses0 + pulses1, 0);

    // R9: both channels together
    linkIdle = 1'b0; funcNonD0 = '0; writeReg(32'h0000_9003);
    tag0 = "R9"; tag1 = "R9"; linkIdle = 1'b1; funcNonD0 = '1;
    pulses0 = 0; pulses1 = 0; runFor(20);
    check("R9", pulses0, 1);
    check("R9", pulses1, 1);

    // random phase
    tag0 = "R3"; tag1 = "R5";
    for (int i = 0; i < 6000; i++) begin
      linkIdle       = ($urandom_range(15) != 0);
      trafficPending = ($urandom_range(19) == 0);
      funcNonD0      = ($urandom_range(11) == 0) ? NF'($urandom) : '1;
      if ($urandom_range(39) == 0) begin
        regWrEn = 1'b1;
        regWrData = {8'($urandom), rndThr(), rndThr()};
      end
      cycle();
      regWrEn = 1'b0;
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #3ms;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule